// File: doc/BRIEF.md
# Striped Rotate-Exchange Unit

This block is a purely combinational bit-permutation unit for a 32-bit datapath. A 32-bit operand is copied into both halves of a 64-bit working word. Five shifter stages then pull bits down by 16, 8, 4, 2 and 1 places. In each stage, every bit position chooses one of two 5-bit amounts, a primary and an alternate, according to its own index bits. It then tests a single bit of the chosen amount to decide whether to take the bit from the higher position or keep its own. In the first stage only, a stripe control inverts the chosen amount at some positions.

When the two amounts are equal and stripe is off, the unit is a plain rotate-right. When they differ, or stripe is on, it produces byte swaps, halfword swaps, nibble interleaves and mixed rotations that a simple barrel rotator cannot produce. The low 32 bits of the last stage are sign-extended onto a 64-bit result bus. There is no clock, reset or handshake: the result follows any change of the inputs in the same evaluation, and any pipelining belongs to the surrounding datapath.

Top module: `stripe_permute_unit`

## Requirements
- R1: Before the first stage, the operand is placed in both the upper and the lower 32 bits of a 64-bit working word. With both amounts 0 and stripe 0, the result equals the operand, sign-extended.
- R2: The first stage acts on positions 0 through 46. A position whose index bit 3 is 1 uses the primary amount, and any other position uses the alternate amount. If bit 4 of that amount is 1, the position takes the bit 16 places above it; otherwise it keeps its own bit.
- R3: When stripe is 1, a first-stage position whose index bit 2 is 0 inverts its chosen amount before testing bit 4. Stripe has no effect on any later stage.
- R4: Three middle stages use the primary amount where index bit k is 1 and the alternate amount otherwise. They test amount bit k+1 and pull from 2^(k+1) places higher. For k = 2 the range is positions 0 to 38, for k = 1 it is 0 to 34, and for k = 0 it is 0 to 32.
- R5: The last stage acts on positions 0 through 31. It always uses the primary amount, tests its bit 0, and pulls from 1 place higher. Bit 0 of the alternate amount never affects the result.
- R6: In every stage, positions above that stage's range keep their value unchanged. In-range positions carry either their own bit or the bit one stage distance above.
- R7: Result bits 63 to 32 all equal result bit 31.
- R8: With equal amounts and stripe 0, the low 32 bits of the result are the operand rotated right by that amount.
- R9: The result changes in the same evaluation as the inputs, without any clock edge.
- R10: For every combination of stripe (2 values), primary amount (32) and alternate amount (32), the result matches a bit-exact staged model for several operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Operand to be permuted |
| amt_pri_i | input | 5 | Primary shift amount |
| amt_alt_i | input | 5 | Alternate shift amount |
| stripe_i | input | 1 | Stripe mode: inverts the chosen first-stage amount at positions with index bit 2 equal to 0 |
| result_o | output | 64 | Permuted low word, sign-extended to 64 bits |

## Verification
Two functions can act on the same first-stage position at once: the per-position choice between the primary and alternate amounts, and the stripe inversion of that choice. The bench provokes this with stripe set while the two amounts differ in bit 4. It judges the result both against a hand-worked nibble interleave and against the staged model, across the whole control space. The rotate case with equal amounts gives a second, independent reference, so a fault in amount selection does not go unnoticed because the model happens to share it.

// File: rtl/spu_pkg.sv
package spu_pkg;

  // Distance a stage pulls bits from, stage 0 being the widest move.
  function automatic int stage_dist(input int data_w, input int k);
    return data_w >> (k + 1);
  endfunction

  // Highest position a stage acts on; everything above passes through.
  function automatic int stage_last(input int data_w, input int k);
    return data_w + stage_dist(data_w, k) - 2;
  endfunction

  // Bit of the chosen amount that a stage tests.
  function automatic int stage_test_bit(input int amt_w, input int k);
    return amt_w - 1 - k;
  endfunction

  // Position index bit that picks primary (1) or alternate (0).
  // The final stage has no alternate; the top feeds it primary twice.
  function automatic int stage_sel_bit(input int amt_w, input int k);
    return (k < amt_w - 1) ? (amt_w - 2 - k) : 0;
  endfunction

  // Position index bit that, when 0, lets stripe flip the first stage.
  function automatic int stripe_idx_bit(input int amt_w);
    return (amt_w >= 3) ? (amt_w - 3) : 0;
  endfunction

endpackage

// File: rtl/spu_replicate.sv
module spu_replicate #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   word_i,
  output logic [2*DATA_W-1:0] dual_o
);
  assign dual_o = {word_i, word_i};
endmodule

// File: rtl/spu_stage.sv
module spu_stage #(
  parameter int WORK_W   = 64,
  parameter int DIST     = 16,
  parameter int LAST     = 46,
  parameter int SEL_BIT  = 3,
  parameter int FLIP_BIT = 2
) (
  input  logic [WORK_W-1:0] din,
  input  logic              pri_bit,
  input  logic              alt_bit,
  input  logic              flip,
  output logic [WORK_W-1:0] dout
);
  for (genvar p = 0; p < WORK_W; p++) begin : g_pos
    if (p <= LAST) begin : g_move
      logic amt_bit;
      logic take;
      if (((p >> SEL_BIT) & 1) == 1) begin : g_pri
        assign amt_bit = pri_bit;
      end else begin : g_alt
        assign amt_bit = alt_bit;
      end
      if (((p >> FLIP_BIT) & 1) == 0) begin : g_flip
        assign take = amt_bit ^ flip;
      end else begin : g_noflip
        assign take = amt_bit;
      end
      assign dout[p] = take ? din[p + DIST] : din[p];
    end else begin : g_keep
      assign dout[p] = din[p];
    end
  end
endmodule

// File: rtl/spu_sign_extend.sv
module spu_sign_extend #(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 64
) (
  input  logic [DATA_W-1:0] low_i,
  output logic [OUT_W-1:0]  wide_o
);
  assign wide_o = {{(OUT_W - DATA_W){low_i[DATA_W-1]}}, low_i};
endmodule

// File: rtl/stripe_permute_unit.sv
module stripe_permute_unit
  import spu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 64
) (
  input  logic [DATA_W-1:0]         src_i,
  input  logic [$clog2(DATA_W)-1:0] amt_pri_i,
  input  logic [$clog2(DATA_W)-1:0] amt_alt_i,
  input  logic                      stripe_i,
  output logic [OUT_W-1:0]          result_o
);
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int WORK_W = 2 * DATA_W;
  localparam int NSTG   = AMT_W;

  logic [NSTG:0][WORK_W-1:0] stage_data;

  spu_replicate #(.DATA_W(DATA_W)) u_rep (
    .word_i (src_i),
    .dual_o (stage_data[0])
  );

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    localparam int D  = stage_dist(DATA_W, k);
    localparam int L  = stage_last(DATA_W, k);
    localparam int TB = stage_test_bit(AMT_W, k);
    localparam int SB = stage_sel_bit(AMT_W, k);
    localparam int FB = (k == 0) ? stripe_idx_bit(AMT_W) : 0;

    logic alt_feed;
    logic flip_feed;
    if (k == NSTG - 1) begin : g_prionly
      assign alt_feed = amt_pri_i[TB];
    end else begin : g_twoamt
      assign alt_feed = amt_alt_i[TB];
    end
    if (k == 0) begin : g_stripe
      assign flip_feed = stripe_i;
    end else begin : g_nostripe
      assign flip_feed = 1'b0;
    end

    spu_stage #(
      .WORK_W   (WORK_W),
      .DIST     (D),
      .LAST     (L),
      .SEL_BIT  (SB),
      .FLIP_BIT (FB)
    ) u_stage (
      .din     (stage_data[k]),
      .pri_bit (amt_pri_i[TB]),
      .alt_bit (alt_feed),
      .flip    (flip_feed),
      .dout    (stage_data[k+1])
    );
  end

  spu_sign_extend #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_sext (
    .low_i  (stage_data[NSTG][DATA_W-1:0]),
    .wide_o (result_o)
  );
endmodule

// File: rtl/spu_checker.sv
module spu_checker
  import spu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 64,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int WORK_W = 2 * DATA_W
) (
  input logic [DATA_W-1:0]             src_i,
  input logic [AMT_W-1:0]              amt_pri_i,
  input logic [AMT_W-1:0]              amt_alt_i,
  input logic                          stripe_i,
  input logic [OUT_W-1:0]              result_o,
  input logic [AMT_W:0][WORK_W-1:0]    stage_data
);
  logic [WORK_W-1:0] rot_full;

  always_comb begin
    rot_full = {src_i, src_i} >> amt_pri_i;
    if (!$isunknown({src_i, amt_pri_i, amt_alt_i, stripe_i})) begin
      // R7
      sign_ext_chk: assert (result_o[OUT_W-1:DATA_W] ==
                            {(OUT_W - DATA_W){result_o[DATA_W-1]}});
      // R8
      rotate_chk: assert (!(amt_pri_i == amt_alt_i && !stripe_i) ||
                          result_o[DATA_W-1:0] == rot_full[DATA_W-1:0]);
      // R1
      identity_chk: assert (!(amt_pri_i == '0 && amt_alt_i == '0 && !stripe_i) ||
                            result_o[DATA_W-1:0] == src_i);
      for (int k = 0; k < AMT_W; k++) begin
        for (int p = 0; p < WORK_W; p++) begin
          if (p > stage_last(DATA_W, k)) begin
            // R6
            passthrough_chk: assert (stage_data[k+1][p] == stage_data[k][p]);
          end else begin
            // R6
            move_source_chk: assert (stage_data[k+1][p] == stage_data[k][p] ||
                                     stage_data[k+1][p] ==
                                     stage_data[k][p + stage_dist(DATA_W, k)]);
          end
        end
      end
    end
  end
endmodule

bind stripe_permute_unit spu_checker #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .src_i      (src_i),
  .amt_pri_i  (amt_pri_i),
  .amt_alt_i  (amt_alt_i),
  .stripe_i   (stripe_i),
  .result_o   (result_o),
  .stage_data (stage_data)
);

// File: tb/stripe_permute_unit_test.sv
module stripe_permute_unit_test;
  logic        clk = 1'b0;
  logic [31:0] src;
  logic [4:0]  pri;
  logic [4:0]  alt;
  logic        stripe;
  logic [63:0] res;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  stripe_permute_unit uut (
    .src_i     (src),
    .amt_pri_i (pri),
    .amt_alt_i (alt),
    .stripe_i  (stripe),
    .result_o  (res)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(input logic [31:0] s, input logic [4:0] p,
                                        input logic [4:0] a, input logic st);
    logic [63:0] w;
    logic [63:0] n;
    w = {s, s};
    for (int k = 0; k < 5; k++) begin
      int d;
      int last;
      d = 16 >> k;
      last = 32 + d - 2;
      n = w;
      for (int i = 0; i <= last; i++) begin
        logic [4:0] am;
        if (k == 4) am = p;
        else am = (((i >> (3 - k)) & 1) == 1) ? p : a;
        if (k == 0 && st && ((i >> 2) & 1) == 0) am = ~am;
        if (am[4-k]) n[i] = w[i + d];
      end
      w = n;
    end
    return sx(w[31:0]);
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic [4:0] p,
                       input logic [4:0] a, input logic st);
    @(negedge clk);
    src = s; pri = p; alt = a; stripe = st;
    #1;
  endtask

  task automatic t_zero_state;
    apply(32'h0, 5'd0, 5'd0, 1'b0);
    check("R1 all-zero inputs", res, 64'h0);
  endtask

  task automatic t_identity;
    apply(32'h1234_5678, 5'd0, 5'd0, 1'b0);
    check("R1 identity", res, 64'h0000_0000_1234_5678);
    apply(32'hFEDC_BA98, 5'd0, 5'd0, 1'b0);
    check("R1 identity negative", res, 64'hFFFF_FFFF_FEDC_BA98);
  endtask

  task automatic t_rotate;
    logic [31:0] ops [3];
    ops[0] = 32'h8000_0001; ops[1] = 32'h1234_5678; ops[2] = 32'hC0DE_F00D;
    for (int o = 0; o < 3; o++) begin
      for (int s = 0; s < 32; s++) begin
        logic [31:0] r;
        r = (ops[o] >> s) | (ops[o] << (32 - s));
        apply(ops[o], 5'(s), 5'(s), 1'b0);
        check("R8 rotate right", res, sx(r));
      end
    end
  endtask

  task automatic t_stage1_select;
    apply(32'h1234_5678, 5'd0, 5'd16, 1'b0);
    check("R2 alternate bit4 moves index-bit3-clear bytes", res, 64'h0000_0000_1278_5634);
    apply(32'h1234_5678, 5'd16, 5'd0, 1'b0);
    check("R2 primary bit4", res, model(32'h1234_5678, 5'd16, 5'd0, 1'b0));
  endtask

  task automatic t_stripe;
    apply(32'h1234_5678, 5'd0, 5'd0, 1'b1);
    check("R3 stripe nibble interleave", res, 64'h0000_0000_1638_5274);
    apply(32'hA5C3_0F96, 5'd16, 5'd3, 1'b1);
    check("R3 stripe with differing amounts", res, model(32'hA5C3_0F96, 5'd16, 5'd3, 1'b1));
    apply(32'hA5C3_0F96, 5'd8, 5'd8, 1'b1);
    check("R3 stripe ignored past first stage", res, model(32'hA5C3_0F96, 5'd8, 5'd8, 1'b1));
  endtask

  task automatic t_middle;
    for (int b = 1; b < 4; b++) begin
      apply(32'h9ABC_DEF0, 5'd0, 5'(1 << b), 1'b0);
      check("R4 alternate middle bit", res, model(32'h9ABC_DEF0, 5'd0, 5'(1 << b), 1'b0));
      apply(32'h9ABC_DEF0, 5'(1 << b), 5'd0, 1'b0);
      check("R4 primary middle bit", res, model(32'h9ABC_DEF0, 5'(1 << b), 5'd0, 1'b0));
    end
  endtask

  task automatic t_last_stage;
    logic [63:0] base;
    apply(32'h0F0F_3355, 5'd6, 5'd6, 1'b0);
    base = res;
    apply(32'h0F0F_3355, 5'd6, 5'd7, 1'b0);
    check("R5 alternate bit0 has no effect", res, base);
    apply(32'h0F0F_3355, 5'd1, 5'd0, 1'b0);
    check("R5 primary bit0 rotates by one", res, sx(32'h8787_99AA));
  endtask

  task automatic t_sign;
    apply(32'h0000_0001, 5'd1, 5'd1, 1'b0);
    check("R7 sign fill from bit31", res, 64'hFFFF_FFFF_8000_0000);
    apply(32'hFFFF_FFFE, 5'd1, 5'd1, 1'b0);
    check("R7 zero fill", res, 64'h0000_0000_7FFF_FFFF);
  endtask

  task automatic t_comb;
    @(negedge clk);
    src = 32'h1234_5678; pri = 5'd0; alt = 5'd0; stripe = 1'b0;
    #1;
    check("R9 first value without edge", res, 64'h0000_0000_1234_5678);
    src = 32'h8765_4321;
    #1;
    check("R9 follows input without edge", res, 64'hFFFF_FFFF_8765_4321);
  endtask

  task automatic t_sweep;
    logic [31:0] ops [4];
    ops[0] = 32'hA5C3_0F96; ops[1] = 32'h8000_0001;
    ops[2] = 32'h0123_4567; ops[3] = $urandom(7);
    for (int o = 0; o < 4; o++)
      for (int st = 0; st < 2; st++)
        for (int p = 0; p < 32; p++)
          for (int a = 0; a < 32; a++) begin
            apply(ops[o], 5'(p), 5'(a), st[0]);
            check("R10 R6 model sweep", res, model(ops[o], 5'(p), 5'(a), st[0]));
          end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_zero_state();
    t_identity();
    t_rotate();
    t_stage1_select();
    t_stripe();
    t_middle();
    t_last_stage();
    t_sign();
    t_comb();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule